// File: doc/BRIEF.md
# I2C Master Bus Condition Sequencer

This block produces the START, repeated START and STOP conditions that an I2C master needs. The host sets two request bits. The start request bit asks for a START. The stop request bit asks for a STOP. The block drives the open-drain enables of SCL and SDA to form each condition. It pulses a done strobe with a kind code when the condition is finished, so that the master's status logic can move to its next step. Byte shifting, arbitration and slave logic sit in neighbouring blocks and are not part of this one.

The block watches the synchronised bus lines at all times. Any START on the bus, including one from another master, marks the bus busy. A STOP marks it idle again and starts a bus-free timer. A fresh START is issued only when the bus is idle and the timer has run out. When the block already owns the bus, a start request gives a repeated START, and a stop request gives a STOP. If both bits are set, the STOP goes first and a START follows once the bus-free time has passed. The stop request bit is cleared by hardware only when a STOP is actually seen on the lines. The start request bit is cleared when the block's START or repeated START completes.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset, both line enables are low (lines released), `master_o`, `bus_busy_o`, `sta_o`, `sto_o` and `done_o` are 0.
- R2: A start request on an idle bus whose bus-free time has run out gives a START: SDA falls while SCL is high, then SCL is pulled low. `done_o` pulses with `done_kind_o` = 2'b01. After that pulse `master_o` is 1 and `sta_o` is 0.
- R3: A start request made while the bus is busy produces no condition until a STOP appears on the lines. The block's SDA fall comes no earlier than TBUF cycles after that STOP, where TBUF = ceil(CLK_MHZ*TBUF_NS/1000), which is 65 by default.
- R4: `bus_busy_o` goes to 1 after any START on the lines, from this block or another master. It goes to 0 after any STOP.
- R5: A start request while `master_o` is 1 gives a repeated START. SDA is released while SCL is low, SCL is released, and then SDA falls while SCL is high. `done_kind_o` = 2'b10, and `master_o` stays 1.
- R6: A stop request while `master_o` is 1 gives a STOP: SDA is pulled low while SCL is low, SCL is released, and then SDA is released. `done_kind_o` = 2'b11. After that `master_o` is 0, and `sto_o` clears only when a STOP has been seen on the lines.
- R7: With both request bits set while master, a STOP (kind 2'b11) comes first and a START (kind 2'b01) follows. The SDA fall of that START comes at least TBUF cycles after the STOP.
- R8: Writing both request bits as 0 produces no condition. A stop request while not master produces no condition and keeps `sto_o` at 1 until some STOP appears on the bus.
- R9: In every generated START or repeated START, SCL is high for at least PHASE_CYC cycles before SDA falls. SDA then stays low for at least PHASE_CYC cycles before SCL is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | Load both request bits from `ctl_sta_i` / `ctl_sto_i` |
| ctl_sta_i | input | 1 | Start request value written |
| ctl_sto_i | input | 1 | Stop request value written |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| sta_o | output | 1 | Current start request bit |
| sto_o | output | 1 | Current stop request bit |
| master_o | output | 1 | Block owns the bus |
| bus_busy_o | output | 1 | A START was seen with no STOP since |
| done_o | output | 1 | One-cycle pulse when a condition is complete |
| done_kind_o | output | 2 | 01 START, 10 repeated START, 11 STOP, valid with `done_o` |

## Verification
A wrong busy flag or bus-free count shows up at the lines as a START that starts too early after a foreign STOP, or as one that never starts. The bench measures this against the line-level STOP time within one bus-free period. A stuck or mis-sequenced FSM state shows up within one phase time as SDA moving while SCL is high outside a condition, or as a done kind out of the expected order. The scoreboard catches this on the next done pulse. A request bit that is cleared wrongly shows up at `sta_o` or `sto_o` as soon as the clearing edge has passed. For the stop bit, it can also show up later as a missing STOP.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RS_REL,
        ST_SETUP,
        ST_FALL,
        ST_P_LOW,
        ST_P_SCLH,
        ST_P_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_START  = 2'b01,
        KIND_RSTART = 2'b10,
        KIND_STOP   = 2'b11
    } cond_kind_e;

endpackage

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch #(
    parameter int SYNC_LEN = 2,
    parameter int TBUF_CYC = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi_o,
    output logic busy_o,
    output logic free_o,
    output logic stop_seen_o
);
    localparam int TW = $clog2(TBUF_CYC + 1);

    typedef struct packed {
        logic [SYNC_LEN-1:0] scl_sh;
        logic [SYNC_LEN-1:0] sda_sh;
        logic                scl_p;
        logic                sda_p;
        logic                busy;
        logic [TW-1:0]       tbuf;
        logic                stop_seen;
    } watch_t;

    watch_t q, d;
    logic   scl_s, sda_s, start_det, stop_det;

    assign scl_s     = q.scl_sh[SYNC_LEN-1];
    assign sda_s     = q.sda_sh[SYNC_LEN-1];
    assign start_det = scl_s && q.scl_p && q.sda_p && !sda_s;
    assign stop_det  = scl_s && q.scl_p && !q.sda_p && sda_s;

    always_comb begin
        d           = q;
        d.scl_sh    = {q.scl_sh[SYNC_LEN-2:0], scl_i};
        d.sda_sh    = {q.sda_sh[SYNC_LEN-2:0], sda_i};
        d.scl_p     = scl_s;
        d.sda_p     = sda_s;
        d.stop_seen = stop_det;
        if (start_det) begin
            d.busy = 1'b1;
            d.tbuf = '0;
        end else if (stop_det) begin
            d.busy = 1'b0;
            d.tbuf = TW'(TBUF_CYC);
        end else if (q.tbuf != '0) begin
            d.tbuf = q.tbuf - TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.scl_sh    <= '1;
            q.sda_sh    <= '1;
            q.scl_p     <= 1'b1;
            q.sda_p     <= 1'b1;
            q.busy      <= 1'b0;
            q.tbuf      <= '0;
            q.stop_seen <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign scl_hi_o    = scl_s;
    assign busy_o      = q.busy;
    assign free_o      = !q.busy && (q.tbuf == '0);
    assign stop_seen_o = q.stop_seen;

    // R4: a START seen on the lines marks the bus busy
    a_r4_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy_o);

    // R4: a STOP seen on the lines frees it and arms the full bus-free wait
    a_r4_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!busy_o && q.tbuf == TW'(TBUF_CYC)));

    // R3: the bus only becomes usable when the bus-free count runs out
    a_r3_free_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(free_o) |-> $past(q.tbuf) == TW'(1));

endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_pkg::*;
#(
    parameter int PHASE_CYC = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sta_req_i,
    input  logic       sto_req_i,
    input  logic       bus_free_i,
    input  logic       bus_busy_i,
    input  logic       scl_hi_i,
    input  logic       stop_seen_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       master_o,
    output logic       sta_ack_o,
    output logic       done_o,
    output logic [1:0] kind_o
);
    localparam int CW = $clog2(PHASE_CYC + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          master;
        logic          rep;
        logic          done;
        cond_kind_e    kind;
    } fsm_t;

    fsm_t q, d;
    logic phase_end;

    assign phase_end = (q.cnt == CW'(PHASE_CYC - 1));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.kind = KIND_NONE;
        unique case (q.state)
            ST_IDLE: begin
                d.cnt = '0;
                if (q.master) begin
                    if (sto_req_i) begin
                        d.state = ST_P_LOW;
                    end else if (sta_req_i) begin
                        d.state = ST_RS_REL;
                        d.rep   = 1'b1;
                    end
                end else if (sta_req_i && bus_free_i) begin
                    d.state = ST_SETUP;
                    d.rep   = 1'b0;
                end
            end
            ST_RS_REL: begin
                if (phase_end) begin
                    d.state = ST_SETUP;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_SETUP: begin
                if (!q.rep && bus_busy_i) begin
                    d.state = ST_IDLE;
                    d.cnt   = '0;
                end else if (!scl_hi_i) begin
                    d.cnt = '0;
                end else if (phase_end) begin
                    d.state = ST_FALL;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_FALL: begin
                if (phase_end) begin
                    d.state  = ST_IDLE;
                    d.cnt    = '0;
                    d.master = 1'b1;
                    d.done   = 1'b1;
                    d.kind   = q.rep ? KIND_RSTART : KIND_START;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_P_LOW: begin
                if (phase_end) begin
                    d.state = ST_P_SCLH;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_P_SCLH: begin
                if (!scl_hi_i) begin
                    d.cnt = '0;
                end else if (phase_end) begin
                    d.state = ST_P_WAIT;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_P_WAIT: begin
                if (stop_seen_i) begin
                    d.state  = ST_IDLE;
                    d.master = 1'b0;
                    d.done   = 1'b1;
                    d.kind   = KIND_STOP;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.cnt    <= '0;
            q.master <= 1'b0;
            q.rep    <= 1'b0;
            q.done   <= 1'b0;
            q.kind   <= KIND_NONE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.state)
            ST_IDLE:   begin scl_oe_o = q.master; sda_oe_o = q.master; end
            ST_RS_REL: begin scl_oe_o = 1'b1;     sda_oe_o = 1'b0;     end
            ST_SETUP:  begin scl_oe_o = 1'b0;     sda_oe_o = 1'b0;     end
            ST_FALL:   begin scl_oe_o = 1'b0;     sda_oe_o = 1'b1;     end
            ST_P_LOW:  begin scl_oe_o = 1'b1;     sda_oe_o = 1'b1;     end
            ST_P_SCLH: begin scl_oe_o = 1'b0;     sda_oe_o = 1'b1;     end
            default:   begin scl_oe_o = 1'b0;     sda_oe_o = 1'b0;     end
        endcase
    end

    assign master_o  = q.master;
    assign sta_ack_o = (q.state == ST_FALL) && phase_end;
    assign done_o    = q.done;
    assign kind_o    = q.kind;

    // R5: a repeated START keeps ownership of the bus
    a_r5_rs_keeps_master: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_o == KIND_RSTART) |-> ($past(q.master) && master_o));

    // R6: a finished STOP gives up ownership
    a_r6_stop_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && kind_o == KIND_STOP) |-> !master_o);

    // R9: SDA is pulled for a START only after SCL was sensed high
    a_r9_fall_after_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_FALL && $past(q.state) == ST_SETUP) |-> $past(scl_hi_i));

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
    parameter int CLK_MHZ   = 50,
    parameter int TBUF_NS   = 1300,
    parameter int PHASE_CYC = 10,
    parameter int SYNC_LEN  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr_i,
    input  logic       ctl_sta_i,
    input  logic       ctl_sto_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       sta_o,
    output logic       sto_o,
    output logic       master_o,
    output logic       bus_busy_o,
    output logic       done_o,
    output logic [1:0] done_kind_o
);
    localparam int TBUF_CYC = (CLK_MHZ * TBUF_NS + 999) / 1000;

    typedef struct packed {
        logic sta;
        logic sto;
    } req_t;

    req_t q, d;
    logic scl_hi, bus_free, stop_seen, sta_ack;

    i2c_bus_watch #(
        .SYNC_LEN (SYNC_LEN),
        .TBUF_CYC (TBUF_CYC)
    ) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_i),
        .sda_i       (sda_i),
        .scl_hi_o    (scl_hi),
        .busy_o      (bus_busy_o),
        .free_o      (bus_free),
        .stop_seen_o (stop_seen)
    );

    i2c_cond_fsm #(
        .PHASE_CYC (PHASE_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sta_req_i   (q.sta),
        .sto_req_i   (q.sto),
        .bus_free_i  (bus_free),
        .bus_busy_i  (bus_busy_o),
        .scl_hi_i    (scl_hi),
        .stop_seen_i (stop_seen),
        .scl_oe_o    (scl_oe_o),
        .sda_oe_o    (sda_oe_o),
        .master_o    (master_o),
        .sta_ack_o   (sta_ack),
        .done_o      (done_o),
        .kind_o      (done_kind_o)
    );

    always_comb begin
        d = q;
        if (ctl_wr_i) begin
            d.sta = ctl_sta_i;
            d.sto = ctl_sto_i;
        end else begin
            if (sta_ack)   d.sta = 1'b0;
            if (stop_seen) d.sto = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sta <= 1'b0;
            q.sto <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sta_o = q.sta;
    assign sto_o = q.sto;

    // R6: the stop request only drops on a STOP seen on the bus or a host write
    a_r6_sto_clears_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.sto) |-> $past(stop_seen || ctl_wr_i));

    // R2: the start request only drops when a START completes or the host writes
    a_r2_sta_clears_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.sta) |-> $past(sta_ack || ctl_wr_i));

endmodule

// File: tb/test_i2c_cond_seq.sv
module test_i2c_cond_seq;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_TBUF   = 65;   // ceil(50*1300/1000)
    localparam int EXP_PHASE  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0, ctl_sta = 1'b0, ctl_sto = 1'b0;
    logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic scl_line, sda_line;
    logic scl_oe, sda_oe, sta_o, sto_o, master, busy, done;
    logic [1:0] kind;

    assign scl_line = !(scl_oe || ext_scl_low);
    assign sda_line = !(sda_oe || ext_sda_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cond_seq i_i2c_cond_seq (
        .clk (clk), .rst_n (rst_n),
        .ctl_wr_i (ctl_wr), .ctl_sta_i (ctl_sta), .ctl_sto_i (ctl_sto),
        .scl_i (scl_line), .sda_i (sda_line),
        .scl_oe_o (scl_oe), .sda_oe_o (sda_oe),
        .sta_o (sta_o), .sto_o (sto_o), .master_o (master),
        .bus_busy_o (busy), .done_o (done), .done_kind_o (kind)
    );

    int n_tests = 0, n_fail = 0;
    int cyc = 0, done_cnt = 0;
    int last_start = 0, last_stop = 0, scl_rise = 0, scl_fall = 0;
    int start_setup = 0, start_hold = 0;
    logic scl_p = 1'b1, sda_p = 1'b1;
    logic [1:0] exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // line monitor: conditions and SCL edges at line level
    always @(negedge clk) begin
        if (scl_line && scl_p && sda_p && !sda_line) begin
            last_start  = cyc;
            start_setup = cyc - scl_rise;
        end
        if (scl_line && scl_p && !sda_p && sda_line) last_stop = cyc;
        if (scl_line && !scl_p) scl_rise = cyc;
        if (!scl_line && scl_p) begin
            scl_fall   = cyc;
            start_hold = cyc - last_start;
        end
        scl_p = scl_line;
        sda_p = sda_line;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected done R8", int'(kind), 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                check(kind == e, "done kind R2/R5/R6/R7", int'(kind), int'(e));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic write_ctl(input logic s, input logic p);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_sta = s; ctl_sto = p;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic expect_kind(input logic [1:0] k);
        exp_q.push_back(k);
    endtask

    task automatic wait_dones(input int n, input string tag);
        int t = 0;
        while (done_cnt < n && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(done_cnt >= n, tag, done_cnt, n);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!scl_oe && !sda_oe, "R1 lines released", int'({scl_oe, sda_oe}), 0);
        check(!master && !busy && !sta_o && !sto_o && !done, "R1 flags clear",
              int'({master, busy, sta_o, sto_o, done}), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 START on a free bus
        expect_kind(2'b01);
        write_ctl(1'b1, 1'b0);
        wait_dones(1, "R2 START done");
        check(master && !sta_o, "R2 master set, sta cleared", int'({master, sta_o}), 2);
        check(!scl_line && !sda_line, "R2 both lines low", int'({scl_line, sda_line}), 0);
        check(start_setup >= EXP_PHASE, "R9 setup before SDA fall", start_setup, EXP_PHASE);
        check(start_hold >= EXP_PHASE, "R9 hold before SCL fall", start_hold, EXP_PHASE);
        check(busy, "R4 busy after own START", int'(busy), 1);

        // R5 repeated START
        base = last_start;
        expect_kind(2'b10);
        write_ctl(1'b1, 1'b0);
        wait_dones(2, "R5 RSTART done");
        check(master && !sta_o, "R5 still master", int'({master, sta_o}), 2);
        check(last_start > base, "R5 new START on lines", last_start, base + 1);
        check(start_setup >= EXP_PHASE && start_hold >= EXP_PHASE, "R9 repeated START timing",
              start_setup, EXP_PHASE);

        // R6 STOP
        base = last_stop;
        expect_kind(2'b11);
        write_ctl(1'b0, 1'b1);
        wait_dones(3, "R6 STOP done");
        check(!master && !sto_o, "R6 master and sto cleared", int'({master, sto_o}), 0);
        check(last_stop > base, "R6 STOP on lines", last_stop, base + 1);
        check(!busy, "R4 idle after STOP", int'(busy), 0);
        check(scl_line && sda_line, "R6 lines released", int'({scl_line, sda_line}), 3);

        // R3 START while another master holds the bus
        repeat (80) @(negedge clk);
        ext_sda_low = 1'b1;
        repeat (6) @(negedge clk);
        check(busy, "R4 busy after foreign START", int'(busy), 1);
        expect_kind(2'b01);
        write_ctl(1'b1, 1'b0);
        repeat (200) @(negedge clk);
        check(done_cnt == 3 && !sda_oe, "R3 held off while busy", done_cnt, 3);
        ext_scl_low = 1'b1;
        repeat (4) @(negedge clk);
        ext_scl_low = 1'b0;
        repeat (4) @(negedge clk);
        ext_sda_low = 1'b0;
        wait_dones(4, "R3 START after free");
        check(last_start - last_stop >= EXP_TBUF, "R3 bus-free gap", last_start - last_stop, EXP_TBUF);
        check(master, "R3 master after queued START", int'(master), 1);

        // R7 both bits: STOP then START
        expect_kind(2'b11);
        expect_kind(2'b01);
        write_ctl(1'b1, 1'b1);
        wait_dones(6, "R7 STOP then START");
        check(last_start - last_stop >= EXP_TBUF, "R7 gap after own STOP", last_start - last_stop, EXP_TBUF);
        check(master && !sta_o && !sto_o, "R7 final flags", int'({master, sta_o, sto_o}), 4);

        // release the bus again
        expect_kind(2'b11);
        write_ctl(1'b0, 1'b1);
        wait_dones(7, "R6 second STOP");

        // R8 zero write and stop request while not master
        write_ctl(1'b0, 1'b0);
        repeat (120) @(negedge clk);
        check(done_cnt == 7 && scl_line && sda_line, "R8 zero write idle", done_cnt, 7);
        write_ctl(1'b0, 1'b1);
        repeat (120) @(negedge clk);
        check(done_cnt == 7 && !scl_oe && !sda_oe, "R8 STO not master no condition", done_cnt, 7);
        check(sto_o, "R8 sto held", int'(sto_o), 1);
        ext_sda_low = 1'b1;
        repeat (6) @(negedge clk);
        ext_scl_low = 1'b1;
        repeat (4) @(negedge clk);
        ext_scl_low = 1'b0;
        repeat (4) @(negedge clk);
        ext_sda_low = 1'b0;
        repeat (6) @(negedge clk);
        check(!sto_o, "R6 sto cleared by foreign STOP", int'(sto_o), 0);
        check(exp_q.size() == 0, "R8 all expected done", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule